// File: doc/BRIEF.md
# Configurable Event Interrupt Router

The router collects 64 active-high pulsed system events. Each event sets a sticky pending bit, and that bit stays set until software clears it. A pending event is forwarded only if its per-event enable is set. Routing then takes two stages. The event-to-channel table puts each event on one of 10 interrupt channels. The channel-to-host table sends each channel to one of 10 host outputs.

For each host, the block reports the winning pending event, or reports that no event is pending. The winner is the event on the lowest-numbered channel, and within that channel the lowest-numbered event. A host line rises only when the global enable is set, that host's own enable is set, and the host has a winner.

All configuration goes through a simple word-addressed 32-bit register bus. The bus has a write strobe and a combinational read port. Enables for events and hosts are set and cleared by writing an index, not a bitmask. Pending status is cleared by writing ones to the bits to clear.

Top module: `evt_irq_router`

## Requirements
- R1: Any cycle in which `evt_in[n]` is high sets pending bit n. The bit stays set until a 1 is written to bit n%32 of the status word at 0x280 (events 0 to 31) or 0x284 (events 32 to 63). Reading these two offsets returns the pending bits.
- R2: If an event is high in the same cycle as a status write that clears it, the pending bit stays set.
- R3: A write to 0x28 sets the enable of the event whose number is in `bus_wdata[5:0]`. A write to 0x2C clears that enable. Reading 0x300 or 0x304 returns the enables for events 0 to 31 or 32 to 63. An event whose enable is clear takes no part in routing, even when it is pending.
- R4: The event-to-channel table is 16 words at 0x400 to 0x43C. Word k holds events 4k to 4k+3. Each event has one byte, and the lowest byte belongs to the lowest event. Only bits [3:0] of each byte are stored, and a read returns them with the other bits at zero. A channel value above 9 routes the event nowhere.
- R5: The channel-to-host table is 3 words at 0x800 to 0x808. Word k holds channels 4k to 4k+3, using the same byte layout and 4-bit storage as R4. A host value above 9 routes the channel nowhere.
- R6: Bit 0 of 0x10 is the global enable. While it is 0, every `host_irq` bit is 0.
- R7: A write to 0x34 sets the enable of the host whose number is in `bus_wdata[3:0]`. A write to 0x38 clears it. Numbers above 9 have no effect. Reading 0x30 returns the host enables in bits [9:0]. `host_irq[h]` is 1 only when the global enable is set, host h's enable is set, and host h has a winner.
- R8: For host h, the winner is the enabled pending event on the lowest channel mapped to h, and within that channel the lowest event number. `host_win_vld[h]` and `host_win_idx[6h+5:6h]` give the winner, whatever the enables of R6 and R7. The word at 0x900+4h returns the winner index in bits [5:0], with bit 31 set when host h has no winner.
- R9: After reset, every enable, pending bit and table entry is 0, and every host output is 0. Unused offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 64 | System events, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| host_irq | output | 10 | Level interrupt per host |
| host_win_vld | output | 10 | Host has a winning event |
| host_win_idx | output | 60 | Winning event per host, 6 bits each |

## Verification
A new event pulse and a status clear for the same event can fall in the same cycle. The bench provokes this by raising the event input during the write cycle of the clear word. It then checks that the status word still shows the bit and that the host still reports that event as its winner. Two events that become pending together on different channels, and on the same channel, are judged the same way: a reference model computes the expected winner from the tables and the enables.

// File: rtl/evr_pkg.sv
package evr_pkg;
    localparam int EVT_N    = 64;
    localparam int CHAN_N   = 10;
    localparam int HOST_N   = 10;
    localparam int MAP_W    = 4;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int LANE_W   = 8;
    localparam int PER_WORD = DATA_W / LANE_W;

    // word addresses (byte offset / 4)
    localparam int GEN_WA     = 'h10  >> 2;
    localparam int EN_SET_WA  = 'h28  >> 2;
    localparam int EN_CLR_WA  = 'h2C  >> 2;
    localparam int HEN_RD_WA  = 'h30  >> 2;
    localparam int HEN_SET_WA = 'h34  >> 2;
    localparam int HEN_CLR_WA = 'h38  >> 2;
    localparam int STAT_WA    = 'h280 >> 2;
    localparam int EN_RD_WA   = 'h300 >> 2;
    localparam int EMAP_WA    = 'h400 >> 2;
    localparam int CMAP_WA    = 'h800 >> 2;
    localparam int WIN_WA     = 'h900 >> 2;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_SET,
        WR_CLR
    } idx_op_e;

    function automatic logic [DATA_W-1:0] win_word(input logic vld,
                                                   input logic [5:0] idx);
        logic [DATA_W-1:0] w;
        w = '0;
        w[DATA_W-1] = ~vld;
        w[5:0] = idx;
        return w;
    endfunction
endpackage

// File: rtl/evr_status.sv
module evr_status #(
    parameter int NE = evr_pkg::EVT_N,
    localparam int EW = $clog2(NE)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NE-1:0]        evt_in,
    input  logic [NE-1:0]        clr_mask,
    input  evr_pkg::idx_op_e     en_op,
    input  logic [EW-1:0]        en_idx,
    output logic [NE-1:0]        pend,
    output logic [NE-1:0]        en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            en   <= '0;
        end else begin
            pend <= (pend & ~clr_mask) | evt_in;
            case (en_op)
                evr_pkg::WR_SET: en[en_idx] <= 1'b1;
                evr_pkg::WR_CLR: en[en_idx] <= 1'b0;
                default: ;
            endcase
        end
    end

    // R1: a pending bit not cleared stays set
    a_r1_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & $past(pend & ~clr_mask)) == $past(pend & ~clr_mask)));
    // R2: an active event always leaves its bit set, even under a clear
    a_r2_pulse_wins: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & $past(evt_in)) == $past(evt_in)));
    // R3: indexed set takes effect on the next cycle
    a_r3_en_set: assert property (@(posedge clk) disable iff (rst)
        (en_op == evr_pkg::WR_SET) |=> en[$past(en_idx)]);
endmodule

// File: rtl/evr_chan_pri.sv
module evr_chan_pri #(
    parameter int NE = evr_pkg::EVT_N,
    parameter int NC = evr_pkg::CHAN_N,
    parameter int MW = evr_pkg::MAP_W,
    localparam int EW = $clog2(NE)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NE-1:0]    act,
    input  logic [NE*MW-1:0] emap,
    output logic [NC-1:0]    chan_hit,
    output logic [NC*EW-1:0] chan_idx
);
    for (genvar c = 0; c < NC; c++) begin : g_ch
        logic          hit_c;
        logic [EW-1:0] idx_c;
        always_comb begin
            hit_c = 1'b0;
            idx_c = '0;
            // descending scan: the lowest matching event is written last
            for (int e = NE - 1; e >= 0; e--) begin
                if (act[e] && emap[e*MW +: MW] == MW'(c)) begin
                    hit_c = 1'b1;
                    idx_c = EW'(e);
                end
            end
        end
        assign chan_hit[c] = hit_c;
        assign chan_idx[c*EW +: EW] = idx_c;

        // R4: a channel's candidate is active and mapped to that channel
        a_r4_chan_match: assert property (@(posedge clk) disable iff (rst)
            chan_hit[c] |-> (act[chan_idx[c*EW +: EW]] &&
                             emap[chan_idx[c*EW +: EW]*MW +: MW] == MW'(c)));
    end
endmodule

// File: rtl/evr_host_sel.sv
module evr_host_sel #(
    parameter int NC = evr_pkg::CHAN_N,
    parameter int NH = evr_pkg::HOST_N,
    parameter int MW = evr_pkg::MAP_W,
    parameter int EW = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NC-1:0]    chan_hit,
    input  logic [NC*EW-1:0] chan_idx,
    input  logic [NC*MW-1:0] cmap,
    output logic [NH-1:0]    host_vld,
    output logic [NH*EW-1:0] host_idx
);
    for (genvar h = 0; h < NH; h++) begin : g_host
        logic          vld_h;
        logic [EW-1:0] idx_h;
        always_comb begin
            vld_h = 1'b0;
            idx_h = '0;
            for (int c = NC - 1; c >= 0; c--) begin
                if (chan_hit[c] && cmap[c*MW +: MW] == MW'(h)) begin
                    vld_h = 1'b1;
                    idx_h = chan_idx[c*EW +: EW];
                end
            end
        end
        assign host_vld[h] = vld_h;
        assign host_idx[h*EW +: EW] = idx_h;

        // R8: a winner exists only if some channel routed to this host hits
        a_r8_host_src: assert property (@(posedge clk) disable iff (rst)
            host_vld[h] |-> (chan_hit != '0));
    end
endmodule

// File: rtl/evt_irq_router.sv
module evt_irq_router #(
    parameter int NUM_EVT  = evr_pkg::EVT_N,
    parameter int NUM_CHAN = evr_pkg::CHAN_N,
    parameter int NUM_HOST = evr_pkg::HOST_N,
    parameter int MAP_W    = evr_pkg::MAP_W,
    parameter int ADDR_W   = evr_pkg::ADDR_W,
    localparam int EW      = $clog2(NUM_EVT),
    localparam int HW      = $clog2(NUM_HOST),
    localparam int WA_W    = ADDR_W - 2,
    localparam int DW      = evr_pkg::DATA_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_EVT-1:0]     evt_in,
    input  logic                   bus_we,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DW-1:0]          bus_wdata,
    output logic [DW-1:0]          bus_rdata,
    output logic [NUM_HOST-1:0]    host_irq,
    output logic [NUM_HOST-1:0]    host_win_vld,
    output logic [NUM_HOST*EW-1:0] host_win_idx
);
    import evr_pkg::*;
    typedef logic [WA_W-1:0] wa_t;

    localparam int LANES = PER_WORD;
    localparam int SW    = NUM_EVT / DW;

    wa_t wa;
    assign wa = bus_addr[ADDR_W-1:2];

    logic                    glob_en;
    logic [NUM_EVT*MAP_W-1:0] emap_q;
    logic [NUM_CHAN*MAP_W-1:0] cmap_q;
    logic [NUM_HOST-1:0]     hen_q;
    logic [NUM_EVT-1:0]      pend, en, clr_mask;
    idx_op_e                 en_op;
    logic [NUM_CHAN-1:0]     chan_hit;
    logic [NUM_CHAN*EW-1:0]  chan_idx;
    logic [HW-1:0]           hidx;

    assign hidx = bus_wdata[HW-1:0];

    // ---------------- write decode ----------------
    always_comb begin
        for (int e = 0; e < NUM_EVT; e++)
            clr_mask[e] = bus_we && (wa == wa_t'(STAT_WA + e / DW)) && bus_wdata[e % DW];
    end

    always_comb begin
        en_op = WR_NONE;
        if (bus_we && wa == wa_t'(EN_SET_WA)) en_op = WR_SET;
        else if (bus_we && wa == wa_t'(EN_CLR_WA)) en_op = WR_CLR;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_en <= 1'b0;
            emap_q  <= '0;
            cmap_q  <= '0;
            hen_q   <= '0;
        end else if (bus_we) begin
            if (wa == wa_t'(GEN_WA)) glob_en <= bus_wdata[0];
            if (wa == wa_t'(HEN_SET_WA) && int'(hidx) < NUM_HOST) hen_q[hidx] <= 1'b1;
            if (wa == wa_t'(HEN_CLR_WA) && int'(hidx) < NUM_HOST) hen_q[hidx] <= 1'b0;
            for (int e = 0; e < NUM_EVT; e++)
                if (wa == wa_t'(EMAP_WA + e / LANES))
                    emap_q[e*MAP_W +: MAP_W] <= bus_wdata[(e % LANES)*LANE_W +: MAP_W];
            for (int c = 0; c < NUM_CHAN; c++)
                if (wa == wa_t'(CMAP_WA + c / LANES))
                    cmap_q[c*MAP_W +: MAP_W] <= bus_wdata[(c % LANES)*LANE_W +: MAP_W];
        end
    end

    // ---------------- datapath ----------------
    evr_status #(.NE(NUM_EVT)) u_status (
        .clk(clk), .rst(rst), .evt_in(evt_in), .clr_mask(clr_mask),
        .en_op(en_op), .en_idx(bus_wdata[EW-1:0]), .pend(pend), .en(en)
    );

    evr_chan_pri #(.NE(NUM_EVT), .NC(NUM_CHAN), .MW(MAP_W)) u_chan (
        .clk(clk), .rst(rst), .act(pend & en), .emap(emap_q),
        .chan_hit(chan_hit), .chan_idx(chan_idx)
    );

    evr_host_sel #(.NC(NUM_CHAN), .NH(NUM_HOST), .MW(MAP_W), .EW(EW)) u_host (
        .clk(clk), .rst(rst), .chan_hit(chan_hit), .chan_idx(chan_idx),
        .cmap(cmap_q), .host_vld(host_win_vld), .host_idx(host_win_idx)
    );

    assign host_irq = {NUM_HOST{glob_en}} & hen_q & host_win_vld;

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        if (wa == wa_t'(GEN_WA)) bus_rdata[0] = glob_en;
        if (wa == wa_t'(HEN_RD_WA)) bus_rdata[NUM_HOST-1:0] = hen_q;
        for (int k = 0; k < SW; k++) begin
            if (wa == wa_t'(STAT_WA + k))  bus_rdata = pend[k*DW +: DW];
            if (wa == wa_t'(EN_RD_WA + k)) bus_rdata = en[k*DW +: DW];
        end
        for (int e = 0; e < NUM_EVT; e++)
            if (wa == wa_t'(EMAP_WA + e / LANES))
                bus_rdata[(e % LANES)*LANE_W +: MAP_W] = emap_q[e*MAP_W +: MAP_W];
        for (int c = 0; c < NUM_CHAN; c++)
            if (wa == wa_t'(CMAP_WA + c / LANES))
                bus_rdata[(c % LANES)*LANE_W +: MAP_W] = cmap_q[c*MAP_W +: MAP_W];
        for (int h = 0; h < NUM_HOST; h++)
            if (wa == wa_t'(WIN_WA + h))
                bus_rdata = win_word(host_win_vld[h], host_win_idx[h*EW +: EW]);
    end

    // ---------------- assertions ----------------
    // R6: global enable low silences all hosts
    a_r6_gen_off: assert property (@(posedge clk) disable iff (rst)
        !glob_en |-> (host_irq == '0));

    for (genvar h = 0; h < NUM_HOST; h++) begin : g_chk
        // R7: a raised host line needs its own enable
        a_r7_hen_gate: assert property (@(posedge clk) disable iff (rst)
            host_irq[h] |-> hen_q[h]);
        // R8: a winner is always an enabled pending event
        a_r8_win_active: assert property (@(posedge clk) disable iff (rst)
            host_win_vld[h] |-> (pend[host_win_idx[h*EW +: EW]] && en[host_win_idx[h*EW +: EW]]));
    end
endmodule

// File: tb/evt_irq_router_test.sv
`timescale 1ns/1ps
module evt_irq_router_test;
    localparam int NE = 64, NH = 10, NC = 10, EW = 6;

    logic            clk = 1'b0;
    logic            rst;
    logic [NE-1:0]   evt_in;
    logic            bus_we;
    logic [11:0]     bus_addr;
    logic [31:0]     bus_wdata;
    logic [31:0]     bus_rdata;
    logic [NH-1:0]   host_irq, host_win_vld;
    logic [NH*EW-1:0] host_win_idx;

    always #4 clk = ~clk;

    evt_irq_router uut (
        .clk(clk), .rst(rst), .evt_in(evt_in), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_irq(host_irq),
        .host_win_vld(host_win_vld), .host_win_idx(host_win_idx)
    );

    int n_chk = 0, n_fail = 0;

    // reference model
    bit      m_pend[NE];
    bit      m_en[NE];
    int      m_emap[NE];
    int      m_cmap[NC];
    bit      m_hen[NH];
    bit      m_ger;

    typedef struct {
        int    host;
        bit    irq;
        bit    vld;
        int    idx;
        string tag;
    } item_t;
    item_t sb[$];

    function automatic void chk(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    function automatic void model_win(input int h, output bit vld, output int idx);
        vld = 0; idx = 0;
        for (int c = 0; c < NC; c++) begin
            if (m_cmap[c] != h) continue;
            for (int e = 0; e < NE; e++)
                if (m_pend[e] && m_en[e] && m_emap[e] == c) begin
                    vld = 1; idx = e; return;
                end
        end
    endfunction

    // driver side: push expected host results, then wait for the monitor
    task automatic expect_hosts(string tag);
        for (int h = 0; h < NH; h++) begin
            item_t it;
            bit v; int i;
            model_win(h, v, i);
            it.host = h; it.vld = v; it.idx = i;
            it.irq = v && m_ger && m_hen[h];
            it.tag = tag;
            sb.push_back(it);
        end
        wait (sb.size() == 0);
    endtask

    // monitor: compare queued expectations away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                chk(host_irq[it.host] == it.irq, $sformatf("%s irq[%0d]", it.tag, it.host),
                    host_irq[it.host], it.irq);
                chk(host_win_vld[it.host] == it.vld, $sformatf("%s vld[%0d]", it.tag, it.host),
                    host_win_vld[it.host], it.vld);
                if (it.vld)
                    chk(int'(host_win_idx[it.host*EW +: EW]) == it.idx,
                        $sformatf("%s idx[%0d]", it.tag, it.host),
                        host_win_idx[it.host*EW +: EW], it.idx);
            end
        end
    end

    task automatic model_write(int a, logic [31:0] d, logic [NE-1:0] ev);
        for (int e = 0; e < NE; e++) begin
            bit clr;
            clr = (a == 'h280 && e < 32 && d[e]) || (a == 'h284 && e >= 32 && d[e-32]);
            if (clr) m_pend[e] = 0;
            if (ev[e]) m_pend[e] = 1;
        end
        if (a == 'h10) m_ger = d[0];
        if (a == 'h28) m_en[d[5:0]] = 1;
        if (a == 'h2C) m_en[d[5:0]] = 0;
        if (a == 'h34 && d[3:0] < NH) m_hen[d[3:0]] = 1;
        if (a == 'h38 && d[3:0] < NH) m_hen[d[3:0]] = 0;
        if (a >= 'h400 && a <= 'h43C)
            for (int b = 0; b < 4; b++) m_emap[(a - 'h400) + b] = int'(d[b*8 +: 4]);
        if (a >= 'h800 && a <= 'h808)
            for (int b = 0; b < 4; b++)
                if ((a - 'h800) + b < NC) m_cmap[(a - 'h800) + b] = int'(d[b*8 +: 4]);
    endtask

    task automatic wr_ev(int a, logic [31:0] d, logic [NE-1:0] ev);
        @(negedge clk);
        bus_we = 1; bus_addr = 12'(a); bus_wdata = d; evt_in = ev;
        @(negedge clk);
        bus_we = 0; evt_in = '0;
        model_write(a, d, ev);
    endtask

    task automatic wr(int a, logic [31:0] d);
        wr_ev(a, d, '0);
    endtask

    task automatic pulse(logic [NE-1:0] ev);
        wr_ev('hFFC, 32'h0, ev);   // unused offset, only the event lines move
    endtask

    task automatic rd(int a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_addr = 12'(a);
        #1;
        chk(bus_rdata == exp, $sformatf("%s rd %0h", tag, a), bus_rdata, exp);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1; evt_in = '0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R9: reset state
        rd('h10, 0, "R9 ger");
        rd('h280, 0, "R9 status");
        rd('h304, 0, "R9 enables");
        rd('h43C, 0, "R9 evt map");
        rd('h800, 0, "R9 chan map");
        rd('h904, 32'h8000_0000, "R9 win none");
        rd('h200, 0, "R9 unused");
        expect_hosts("R9 outputs");

        // R4 R5: event 5 -> channel 2 -> host 3
        wr('h404, 32'h0000_0200);
        wr('h800, 32'h0003_0000);
        wr('h28, 5);
        pulse(64'h20);
        rd('h280, 32'h20, "R1 status set");
        expect_hosts("R6 ger low");          // host3 winner but irq low
        wr('h10, 1);
        expect_hosts("R7 host disabled");
        wr('h34, 3);
        expect_hosts("R7 host enabled");
        rd('h30, 32'h8, "R7 hen read");
        wr('h34, 12);                         // out-of-range host number
        rd('h30, 32'h8, "R7 hen ignore");

        // R8: lower channel beats lower event
        wr('h428, 32'h0000_0001);             // event 40 -> channel 1
        wr('h800, 32'h0003_0300);             // channel 1 -> host 3
        wr('h28, 40);
        pulse(64'h1 << 40);
        expect_hosts("R8 lower channel");
        rd('h90C, 32'd40, "R8 win reg");

        // R8: same channel, lower event wins (events 7 and 40 together)
        wr('h404, 32'h0100_0200);             // event 7 -> channel 1
        wr('h28, 7);
        pulse((64'h1 << 40) | 64'h80);
        expect_hosts("R8 lower event");

        // R1: W1C clears event 7
        wr('h280, 32'h80);
        rd('h280, 32'h20, "R1 w1c low word");
        expect_hosts("R1 after clear");

        // R2: pulse and clear of event 40 in the same cycle
        wr_ev('h284, 32'h100, 64'h1 << 40);
        rd('h284, 32'h100, "R2 pulse wins");
        expect_hosts("R2 route");
        wr('h284, 32'h100);
        rd('h284, 32'h0, "R1 w1c high word");

        // R3: disabled pending event does not route
        pulse(64'h1 << 40);
        wr('h2C, 40);
        rd('h304, 32'h0, "R3 en clear");
        rd('h300, 32'hA0, "R3 en low word");
        expect_hosts("R3 disabled pending");

        // R4: nibble storage and out-of-range channel
        wr('h404, 32'hF100_0CF0);
        rd('h404, 32'h0100_0C00, "R4 nibble readback");
        expect_hosts("R4 channel above 9");

        // R5: host above 9 and the last map word
        wr('h404, 32'h0000_0900);             // event 5 -> channel 9
        wr('h808, 32'h0000_0F00);             // channel 9 -> host 15
        expect_hosts("R5 host above 9");
        wr('h808, 32'hFF00_0300);
        rd('h808, 32'h0000_0300, "R5 readback");
        expect_hosts("R5 channel 9");

        // default routing: event 0 on channel 0 to host 0
        wr('h28, 0);
        wr('h34, 0);
        pulse(64'h1);
        expect_hosts("R8 host0");

        // R6: global disable drops every line
        wr('h10, 0);
        expect_hosts("R6 ger cleared");
        wr('h10, 1);
        wr('h38, 3);
        expect_hosts("R7 host cleared");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule